// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches one pin out of a set of ports, each carrying 16 asynchronous pins. It raises an interrupt when that pin meets any of four conditions, each enabled on its own: high level, low level, rising edge and falling edge. Every pin is first passed through a two-stage synchronizer. Port and pin selector fields in a control register then choose the source. Edges are found by comparing the selected, synchronised value with its value one cycle earlier.

A status register holds three sticky bits: the combined interrupt, a rising-edge record and a falling-edge record. Software clears them by writing 1. Clearing the combined bit also clears both edge records. A mask bit gates the interrupt output without stopping status updates. Software changes the mask only through two write-only strobe bits, one that sets it and one that clears it. A chip may instance several of these channels side by side. Prioritising between channels happens elsewhere.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, the control register, the status register, the mask and irq_o all read 0.
- R2: The control register holds the pin index in bits 11:8 and the port index in bits 15:12. Only the pin at bus position port*16+pin can set status. Activity on any other pin leaves status at 0.
- R3: With the high-level enable (control bit 0) set and the selected pin at 1, status bit 0 sets. Status bit 0 is set again on every cycle the level stays, so a clearing write has no lasting effect. After the pin returns to 0, a clear stays cleared.
- R4: With the low-level enable (control bit 1) set and the selected pin at 0, status bit 0 sets.
- R5: With the rise enable (control bit 2) set, a 0-to-1 change on the selected pin sets status bit 1 (rise record) and status bit 0.
- R6: With the fall enable (control bit 3) set, a 1-to-0 change on the selected pin sets status bit 2 (fall record) and status bit 0.
- R7: Writing 1 to status bit 0 clears status bits 0, 1 and 2.
- R8: Writing 1 to status bit 1 or bit 2 alone clears only that bit. Writing 0 to a status bit has no effect.
- R9: irq_o is 1 exactly when status bit 0 is 1 and the mask is 1. Status still sets while the mask is 0.
- R10: Writing 1 to status bit 3 sets the mask. Writing 1 to status bit 4 clears it, and this clear wins when both are written in the same write. Both strobe bits always read 0. The mask value reads back at control bit 4, and writes to the control register do not change it.
- R11: When a hardware set and a software clear of a status bit fall in the same cycle, the bit ends up set.
- R12: A change on an input pin reaches status three clock edges after it is presented: two synchronizer stages and then the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pins_i | input | NUM_PORTS*16 | Asynchronous pin bus, port p in bits p*16+15 down to p*16 |
| irq_o | output | 1 | Masked interrupt |

## Verification
A wrong selector decode shows up as status being set by a neighbouring pin. The sweep catches it within four cycles of toggling that neighbour. A stuck or missing previous-value register loses the edge records, or duplicates them in the wrong bit, on the third edge after the pin moves. A wrong clear or priority path shows up at the next status read after the write. Mask faults appear on irq_o one cycle after a strobe write.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FLD_W  = 4;
  // control register bit positions
  localparam int unsigned C_HI   = 0;
  localparam int unsigned C_LO   = 1;
  localparam int unsigned C_RISE = 2;
  localparam int unsigned C_FALL = 3;
  localparam int unsigned C_MASK = 4;
  localparam int unsigned C_PIN  = 8;
  localparam int unsigned C_PORT = 12;
  // status register bit positions
  localparam int unsigned S_IRQ  = 0;
  localparam int unsigned S_RISE = 1;
  localparam int unsigned S_FALL = 2;
  localparam int unsigned S_MSET = 3;
  localparam int unsigned S_MCLR = 4;

  typedef struct packed {
    logic [FLD_W-1:0] port;
    logic [FLD_W-1:0] pin;
    logic             fall_en;
    logic             rise_en;
    logic             lo_en;
    logic             hi_en;
  } ctrl_t;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/pin_select.sv
module pin_select #(
  parameter int unsigned NUM_PORTS = 2,
  parameter int unsigned PINS      = 16,
  parameter int unsigned FLD_W     = 4
) (
  input  logic [NUM_PORTS*PINS-1:0] bus_i,
  input  logic [FLD_W-1:0]          port_i,
  input  logic [FLD_W-1:0]          pin_i,
  output logic                      pin_o
);
  localparam int unsigned TOTAL = NUM_PORTS * PINS;

  always_comb begin
    pin_o = 1'b0;
    for (int i = 0; i < TOTAL; i++) begin
      if ((32'(port_i) == i / PINS) && (32'(pin_i) == i % PINS)) pin_o = bus_i[i];
    end
  end
endmodule

// File: rtl/pin_event_detect.sv
module pin_event_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic hi_en_i,
  input  logic lo_en_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  output logic rise_ev_o,
  output logic fall_ev_o,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= pin_i;
  end

  assign rise_ev_o = rise_en_i & pin_i & ~prev_q;
  assign fall_ev_o = fall_en_i & ~pin_i & prev_q;
  assign hit_o = (hi_en_i & pin_i) | (lo_en_i & ~pin_i) | rise_ev_o | fall_ev_o;
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq
  import pin_irq_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned PINS        = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic                      addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [NUM_PORTS*PINS-1:0] pins_i,
  output logic                      irq_o
);
  localparam int unsigned BUS_W = NUM_PORTS * PINS;

  ctrl_t ctrl_q;
  logic mask_q, irq_st_q, rise_st_q, fall_st_q;
  logic [BUS_W-1:0] sync_bus;
  logic sel_pin, rise_ev, fall_ev, hit;
  logic wr_ctrl, wr_stat;
  logic unused_wdata;

  assign wr_ctrl = we_i & ~addr_i;
  assign wr_stat = we_i & addr_i;
  assign unused_wdata = ^{wdata_i[DATA_W-1:16], wdata_i[7:4]};

  pin_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pins_i), .q_o(sync_bus)
  );

  pin_select #(.NUM_PORTS(NUM_PORTS), .PINS(PINS), .FLD_W(FLD_W)) u_sel (
    .bus_i(sync_bus), .port_i(ctrl_q.port), .pin_i(ctrl_q.pin), .pin_o(sel_pin)
  );

  pin_event_detect u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(sel_pin),
    .hi_en_i(ctrl_q.hi_en), .lo_en_i(ctrl_q.lo_en),
    .rise_en_i(ctrl_q.rise_en), .fall_en_i(ctrl_q.fall_en),
    .rise_ev_o(rise_ev), .fall_ev_o(fall_ev), .hit_o(hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.port    <= wdata_i[C_PORT +: FLD_W];
      ctrl_q.pin     <= wdata_i[C_PIN +: FLD_W];
      ctrl_q.fall_en <= wdata_i[C_FALL];
      ctrl_q.rise_en <= wdata_i[C_RISE];
      ctrl_q.lo_en   <= wdata_i[C_LO];
      ctrl_q.hi_en   <= wdata_i[C_HI];
    end
  end

  // hardware set has priority over software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_st_q  <= 1'b0;
      rise_st_q <= 1'b0;
      fall_st_q <= 1'b0;
      mask_q    <= 1'b0;
    end else begin
      irq_st_q  <= hit | (irq_st_q & ~(wr_stat & wdata_i[S_IRQ]));
      rise_st_q <= rise_ev |
                   (rise_st_q & ~(wr_stat & (wdata_i[S_RISE] | wdata_i[S_IRQ])));
      fall_st_q <= fall_ev |
                   (fall_st_q & ~(wr_stat & (wdata_i[S_FALL] | wdata_i[S_IRQ])));
      if (wr_stat && wdata_i[S_MCLR]) mask_q <= 1'b0;
      else if (wr_stat && wdata_i[S_MSET]) mask_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i) begin
      rdata_o[S_IRQ]  = irq_st_q;
      rdata_o[S_RISE] = rise_st_q;
      rdata_o[S_FALL] = fall_st_q;
    end else begin
      rdata_o[C_PORT +: FLD_W] = ctrl_q.port;
      rdata_o[C_PIN +: FLD_W]  = ctrl_q.pin;
      rdata_o[C_MASK] = mask_q;
      rdata_o[C_FALL] = ctrl_q.fall_en;
      rdata_o[C_RISE] = ctrl_q.rise_en;
      rdata_o[C_LO]   = ctrl_q.lo_en;
      rdata_o[C_HI]   = ctrl_q.hi_en;
    end
  end

  assign irq_o = irq_st_q & mask_q;
endmodule

// File: rtl/pin_event_irq_chk.sv
module pin_event_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic        addr_i,
  input logic [31:0] wdata_i,
  input logic        irq_o,
  input logic        irq_st_i,
  input logic        rise_st_i,
  input logic        fall_st_i,
  input logic        mask_i,
  input logic        rise_en_i,
  input logic        rise_ev_i,
  input logic        fall_ev_i,
  input logic        hit_i
);
  a_r9_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_st_i && mask_i));

  a_r7_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i && wdata_i[0] && !rise_ev_i && !fall_ev_i) |=> (!rise_st_i && !fall_st_i));

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> irq_st_i);

  a_r5_rise_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rise_st_i) |-> $past(rise_en_i));

  a_r10_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i && wdata_i[3] && !wdata_i[4]) |=> mask_i);

  a_r10_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i && wdata_i[4]) |=> !mask_i);
endmodule

bind pin_event_irq pin_event_irq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .irq_o(irq_o), .irq_st_i(irq_st_q), .rise_st_i(rise_st_q), .fall_st_i(fall_st_q),
  .mask_i(mask_q), .rise_en_i(ctrl_q.rise_en), .rise_ev_i(rise_ev),
  .fall_ev_i(fall_ev), .hit_i(hit)
);

// File: tb/tb_pin_event_irq.sv
module tb_pin_event_irq;
  localparam int NP = 2;
  localparam int NB = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic we_i = 1'b0;
  logic addr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NP*NB-1:0] pins_i = '0;
  logic irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  pin_event_irq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pins_i(pins_i), .irq_o(irq_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  function automatic logic [31:0] cfg(input int p, input int b, input logic [3:0] en);
    return (32'(p) << 12) | (32'(b) << 8) | 32'(en);
  endfunction

  task automatic select_src(input int p, input int b, input logic [3:0] en);
    wr(1'b0, cfg(p, b, 4'b0));
    cyc(2);
    wr(1'b1, 32'h7);
    wr(1'b0, cfg(p, b, en));
  endtask

  initial begin
    logic [31:0] r;
    cyc(3);
    rst_ni = 1'b1;
    cyc(1);
    rd(1'b0, r); chk(r, 32'h0, "R1 control after reset");
    rd(1'b1, r); chk(r, 32'h0, "R1 status after reset");
    chk(32'(irq_o), 0, "R1 irq_o after reset");

    // sweep every pin of every port with edge enables
    for (int p = 0; p < NP; p++) begin
      for (int b = 0; b < NB; b++) begin
        int nb;
        nb = (b + 1) % NB;
        select_src(p, b, 4'b1100);
        pins_i[p*NB+nb] = 1'b1; pins_i[(1-p)*NB+b] = 1'b1;
        cyc(4);
        pins_i[p*NB+nb] = 1'b0; pins_i[(1-p)*NB+b] = 1'b0;
        cyc(4);
        rd(1'b1, r); chk(r, 32'h0, "R2 other pins ignored");
        pins_i[p*NB+b] = 1'b1;
        cyc(4);
        rd(1'b1, r); chk(r, 32'h3, "R5 rise sets rise and irq");
        wr(1'b1, 32'h1);
        rd(1'b1, r); chk(r, 32'h0, "R7 irq clear clears edges");
        pins_i[p*NB+b] = 1'b0;
        cyc(4);
        rd(1'b1, r); chk(r, 32'h5, "R6 fall sets fall and irq");
        wr(1'b1, 32'h4);
        rd(1'b1, r); chk(r, 32'h1, "R8 fall clear alone");
        wr(1'b1, 32'h0);
        rd(1'b1, r); chk(r, 32'h1, "R8 write 0 no effect");
        wr(1'b1, 32'h1);
        rd(1'b1, r); chk(r, 32'h0, "R7 irq clear");
      end
    end

    // latency: pin presented at a negedge, status after third posedge
    select_src(1, 5, 4'b0100);
    pins_i[NB+5] = 1'b1;
    cyc(2);
    rd(1'b1, r); chk(r, 32'h0, "R12 not yet after two edges");
    cyc(1);
    rd(1'b1, r); chk(r, 32'h3, "R12 set after three edges");
    wr(1'b1, 32'h2);
    rd(1'b1, r); chk(r, 32'h1, "R8 rise clear alone");
    pins_i[NB+5] = 1'b0;
    cyc(3);

    // high level, mask behaviour
    select_src(1, 5, 4'b0001);
    pins_i[NB+5] = 1'b1;
    cyc(4);
    rd(1'b1, r); chk(r, 32'h1, "R3 high level sets");
    chk(32'(irq_o), 0, "R9 masked output low, status set");
    wr(1'b1, 32'h1);
    rd(1'b1, r); chk(r, 32'h1, "R11 set wins over clear");
    wr(1'b1, 32'h8);
    chk(32'(irq_o), 1, "R9 unmasked output high");
    rd(1'b0, r); chk(r, cfg(1, 5, 4'b0001) | 32'h10, "R10 mask reads in control");
    rd(1'b1, r); chk(r & 32'h18, 32'h0, "R10 strobes read 0");
    wr(1'b0, cfg(1, 5, 4'b0001));
    rd(1'b0, r); chk(r & 32'h10, 32'h10, "R10 control write keeps mask");
    wr(1'b1, 32'h10);
    chk(32'(irq_o), 0, "R10 mask clear");
    wr(1'b1, 32'h8);
    wr(1'b1, 32'h18);
    chk(32'(irq_o), 0, "R10 clear wins over set");
    pins_i[NB+5] = 1'b0;
    cyc(3);
    wr(1'b1, 32'h1);
    cyc(2);
    rd(1'b1, r); chk(r, 32'h0, "R3 clear holds after level gone");

    // low level
    select_src(0, 9, 4'b0010);
    cyc(2);
    rd(1'b1, r); chk(r, 32'h1, "R4 low level sets");
    pins_i[9] = 1'b1;
    cyc(4);
    wr(1'b1, 32'h1);
    rd(1'b1, r); chk(r, 32'h0, "R4 clear holds when pin high");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule